// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits on a core's store path, in front of a coherent data cache. A retiring store is written into a small queue in a single cycle, so the core goes on executing while the cache is still obtaining ownership of the line or collecting invalidation acknowledgements. The oldest queued store is offered to the cache. It leaves the queue in the cycle the cache grants write permission. At most one store leaves per cycle, and stores always leave in the order they arrived.

Loads look up the queue in the same cycle they are presented. If one or more queued stores target the load's address, the data of the most recently queued of them is returned, and the load is marked as forwarded. Otherwise the load is passed to the cache read port and the cache's data is returned. A barrier input stops all further stores and loads until every queued store has been written to the cache. This restores strict ordering around synchronisation points.

Top module: `store_buf_fwd`

## Requirements
- R1: When the queue is neither full nor held by a barrier, `st_ready` is high, and a store with `st_valid` high is taken in that cycle and becomes visible to loads and to the drain port from the next cycle.
- R2: When `DEPTH` stores are queued, `st_ready` is low. A store presented then is dropped and never appears on the drain port.
- R3: A load (`ld_valid` and `ld_ready` high) whose address equals that of a queued store raises `ld_fwd`, and `ld_data` carries the queued store's data.
- R4: When several queued stores match the load address, `ld_data` is the data of the most recently accepted of them.
- R5: A load with no matching queued store keeps `ld_fwd` low, raises `cache_rd_en` with `cache_rd_addr` equal to `ld_addr`, and returns `cache_rd_data` on `ld_data`.
- R6: `wr_valid` is high exactly when the queue is non-empty. `wr_addr`/`wr_data` show the oldest queued store, which is removed on a cycle with `wr_grant` high. At most one store is removed per cycle.
- R7: A store accepted in the same cycle as a drain leaves the occupancy unchanged, and both take effect.
- R8: `fence_in` high while stores are queued drives `st_ready` and `ld_ready` low. They stay low, even after `fence_in` falls, until the cycle after the last store drains. `fence_in` with an empty queue blocks nothing.
- R9: A store accepted in a cycle is not forwarded to a load presented in the same cycle. That load counts as older.
- R10: After reset the queue is empty: `wr_valid` and `ld_fwd` are low and `st_ready` and `ld_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request from the core |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_ready | output | 1 | Store can be accepted this cycle |
| ld_valid | input | 1 | Load request from the core |
| ld_addr | input | AW | Load word address |
| ld_ready | output | 1 | Load can be served this cycle |
| ld_fwd | output | 1 | Load data came from the queue |
| ld_data | output | DW | Load result (queue or cache) |
| cache_rd_en | output | 1 | Load sent to the cache |
| cache_rd_addr | output | AW | Cache read address |
| cache_rd_data | input | DW | Cache read data, same cycle |
| wr_valid | output | 1 | Oldest queued store offered to the cache |
| wr_addr | output | AW | Address of the offered store |
| wr_data | output | DW | Data of the offered store |
| wr_grant | input | 1 | Cache write permission; offered store is removed |
| fence_in | input | 1 | Memory barrier request |

## Verification
The bench first fills the queue with two stores to one address and checks every load address while the queue is full. A design that searched from the wrong end, or that ignored the live-entry count, would return the older value or stale data from a drained slot. It presents a store while the queue is full and then drains everything in order, so a queue that accepted the extra store would show it on the drain port. It also checks a store and a drain in the same cycle, and a store and a matching load in the same cycle. Occupancy drift or early forwarding in those cases shows up in later loads and drains. Barriers are raised with stores pending and with none pending, and a long pseudo-random mix follows. A barrier that released when `fence_in` fell, rather than when the queue emptied, would let a load through too early.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
    typedef enum logic {
        FENCE_IDLE = 1'b0,
        FENCE_WAIT = 1'b1
    } fence_e;
endpackage

// File: rtl/sbf_fence_ctl.sv
module sbf_fence_ctl
    import sbf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fence_in,
    input  logic empty_now,
    input  logic empty_next,
    output logic blocked
);
    fence_e state_d, state_q;

    always_comb begin
        blocked = (state_q == FENCE_WAIT) | (fence_in & ~empty_now);
        state_d = (blocked & ~empty_next) ? FENCE_WAIT : FENCE_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FENCE_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/sbf_fwd_search.sv
module sbf_fwd_search #(
    parameter int DEPTH = 4,
    parameter int AW    = 4,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [PW-1:0] head,
    input  logic [CW-1:0] count,
    input  logic [AW-1:0] slot_addr [DEPTH],
    input  logic [DW-1:0] slot_data [DEPTH],
    input  logic [AW-1:0] key,
    output logic          hit,
    output logic [DW-1:0] data
);
    logic [PW-1:0] age   [DEPTH];
    logic [DEPTH-1:0] match;

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        assign age[s]   = PW'(s) - head;
        assign match[s] = (CW'(age[s]) < count) && (slot_addr[s] == key);
    end

    always_comb begin
        logic [PW-1:0] best_age;
        hit      = 1'b0;
        data     = '0;
        best_age = '0;
        for (int s = 0; s < DEPTH; s++) begin
            if (match[s] && (!hit || age[s] > best_age)) begin
                hit      = 1'b1;
                best_age = age[s];
                data     = slot_data[s];
            end
        end
    end
endmodule

// File: rtl/store_buf_fwd.sv
module store_buf_fwd #(
    parameter int DEPTH = 4,
    parameter int AW    = 4,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    output logic          st_ready,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_ready,
    output logic          ld_fwd,
    output logic [DW-1:0] ld_data,
    output logic          cache_rd_en,
    output logic [AW-1:0] cache_rd_addr,
    input  logic [DW-1:0] cache_rd_data,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    input  logic          wr_grant,
    input  logic          fence_in
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] head;
        logic [PW-1:0] tail;
        logic [CW-1:0] count;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic [AW-1:0] addr_d [DEPTH];
    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_d [DEPTH];
    logic [DW-1:0] data_q [DEPTH];

    logic          blocked;
    logic          st_fire, dr_fire;
    logic          fwd_hit;
    logic [DW-1:0] fwd_data;
    logic [CW-1:0] occ;

    assign occ = ctl_q.count;

    sbf_fwd_search #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_search (
        .head      (ctl_q.head),
        .count     (ctl_q.count),
        .slot_addr (addr_q),
        .slot_data (data_q),
        .key       (ld_addr),
        .hit       (fwd_hit),
        .data      (fwd_data)
    );

    sbf_fence_ctl i_fence (
        .clk        (clk),
        .rst_n      (rst_n),
        .fence_in   (fence_in),
        .empty_now  (ctl_q.count == '0),
        .empty_next (ctl_d.count == '0),
        .blocked    (blocked)
    );

    always_comb begin
        st_ready      = (ctl_q.count != CW'(DEPTH)) & ~blocked;
        ld_ready      = ~blocked;
        st_fire       = st_valid & st_ready;
        wr_valid      = (ctl_q.count != '0);
        dr_fire       = wr_valid & wr_grant;
        wr_addr       = addr_q[ctl_q.head];
        wr_data       = data_q[ctl_q.head];
        ld_fwd        = ld_valid & ld_ready & fwd_hit;
        cache_rd_en   = ld_valid & ld_ready & ~fwd_hit;
        cache_rd_addr = ld_addr;
        ld_data       = fwd_hit ? fwd_data : cache_rd_data;

        ctl_d  = ctl_q;
        addr_d = addr_q;
        data_d = data_q;
        if (st_fire) begin
            addr_d[ctl_q.tail] = st_addr;
            data_d[ctl_q.tail] = st_data;
            ctl_d.tail         = ctl_q.tail + 1'b1;
        end
        if (dr_fire) begin
            ctl_d.head = ctl_q.head + 1'b1;
        end
        ctl_d.count = ctl_q.count + CW'(st_fire) - CW'(dr_fire);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_ff @(posedge clk) begin
        addr_q <= addr_d;
        data_q <= data_d;
    end
endmodule

// File: rtl/sbf_checker.sv
module sbf_checker #(
    parameter int DEPTH = 4,
    parameter int AW    = 4,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_valid,
    input logic          st_ready,
    input logic          ld_valid,
    input logic          ld_ready,
    input logic          ld_fwd,
    input logic          cache_rd_en,
    input logic          wr_valid,
    input logic          wr_grant,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          fence_in,
    input logic [CW-1:0] occ
);
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    a_r2_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CW'(DEPTH)) |-> !st_ready);

    a_r7_occ_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> occ == $past(occ) + CW'($past(st_valid && st_ready))
                                   - CW'($past(wr_valid && wr_grant)));

    a_r6_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_grant) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    a_r8_fence_block: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_in && wr_valid) |-> (!st_ready && !ld_ready));

    a_r5_miss_to_cache: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ready && !ld_fwd) |-> cache_rd_en);

    a_r3_no_fwd_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |-> !ld_fwd);
endmodule

bind store_buf_fwd sbf_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_sbf_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_valid    (st_valid),
    .st_ready    (st_ready),
    .ld_valid    (ld_valid),
    .ld_ready    (ld_ready),
    .ld_fwd      (ld_fwd),
    .cache_rd_en (cache_rd_en),
    .wr_valid    (wr_valid),
    .wr_grant    (wr_grant),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .fence_in    (fence_in),
    .occ         (occ)
);

// File: tb/test_store_buf_fwd.sv
module test_store_buf_fwd;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int AW    = 4;
    localparam int DW    = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic st_valid, ld_valid, wr_grant, fence_in;
    logic [AW-1:0] st_addr, ld_addr, cache_rd_addr, wr_addr;
    logic [DW-1:0] st_data, ld_data, cache_rd_data, wr_data;
    logic st_ready, ld_ready, ld_fwd, cache_rd_en, wr_valid;

    int checks = 0;
    int errors = 0;

    logic [AW-1:0] ma [DEPTH];
    logic [DW-1:0] md [DEPTH];
    int  mc  = 0;
    bit  mbar = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    store_buf_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_store_buf_fwd (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_ready(ld_ready), .ld_fwd(ld_fwd),
        .ld_data(ld_data), .cache_rd_en(cache_rd_en), .cache_rd_addr(cache_rd_addr),
        .cache_rd_data(cache_rd_data), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_grant(wr_grant), .fence_in(fence_in)
    );

    assign cache_rd_data = {4'h5, ld_addr};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                        input bit lv, input logic [AW-1:0] la, input bit fc, input bit gr);
        bit e_blk, e_sr, e_lr, e_hit, sfire, dfire;
        logic [DW-1:0] e_d;
        int oldc;
        @(negedge clk);
        st_valid = sv; st_addr = sa; st_data = sd;
        ld_valid = lv; ld_addr = la; fence_in = fc; wr_grant = gr;
        #1;
        e_blk = mbar || (fc && mc != 0);
        e_sr  = (mc != DEPTH) && !e_blk;
        e_lr  = !e_blk;
        e_hit = 0; e_d = '0;
        for (int i = 0; i < mc; i++) if (ma[i] == la) begin e_hit = 1; e_d = md[i]; end
        chk("R1/R2/R8 st_ready", 32'(st_ready), 32'(e_sr));
        chk("R8 ld_ready", 32'(ld_ready), 32'(e_lr));
        chk("R3/R9 ld_fwd", 32'(ld_fwd), 32'(lv && e_lr && e_hit));
        chk("R5 cache_rd_en", 32'(cache_rd_en), 32'(lv && e_lr && !e_hit));
        if (lv && e_lr) begin
            chk("R3/R4/R5/R9 ld_data", 32'(ld_data), e_hit ? 32'(e_d) : 32'({4'h5, la}));
            if (!e_hit) chk("R5 cache_rd_addr", 32'(cache_rd_addr), 32'(la));
        end
        chk("R6/R7 wr_valid", 32'(wr_valid), 32'(mc != 0));
        if (mc != 0) begin
            chk("R6/R2 wr_addr", 32'(wr_addr), 32'(ma[0]));
            chk("R6/R2 wr_data", 32'(wr_data), 32'(md[0]));
        end
        sfire = sv && e_sr;
        dfire = gr && mc != 0;
        oldc  = mc;
        if (dfire) begin
            for (int i = 0; i < DEPTH - 1; i++) begin ma[i] = ma[i+1]; md[i] = md[i+1]; end
            mc--;
        end
        if (sfire) begin ma[mc] = sa; md[mc] = sd; mc++; end
        mbar = (mbar || (fc && oldc != 0)) && (mc != 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] r;
        rst_n = 0; st_valid = 0; ld_valid = 0; wr_grant = 0; fence_in = 0;
        st_addr = '0; st_data = '0; ld_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R10: reset state
        chk("R10 wr_valid", 32'(wr_valid), 0);
        chk("R10 st_ready", 32'(st_ready), 1);
        chk("R10 ld_ready", 32'(ld_ready), 1);
        rst_n = 1;

        // Fill; first store meets a same-cycle load to its own address (R9)
        step(1, 4'd1, 8'h11, 1, 4'd1, 0, 0);
        step(1, 4'd2, 8'h22, 1, 4'd1, 0, 0);
        step(1, 4'd1, 8'h33, 1, 4'd1, 0, 0);
        step(1, 4'd3, 8'h44, 1, 4'd1, 0, 0);
        // Full: every load address, youngest match for 1 (R3, R4, R5)
        for (int a = 0; a < 16; a++) step(0, '0, '0, 1, 4'(a), 0, 0);
        // Store while full is dropped (R2)
        step(1, 4'd5, 8'h55, 1, 4'd5, 0, 0);
        // One drain, then store and drain together (R7)
        step(0, '0, '0, 1, 4'd1, 0, 1);
        step(1, 4'd6, 8'h66, 1, 4'd6, 0, 1);
        step(0, '0, '0, 1, 4'd6, 0, 0);
        // Drain remainder in order (R6)
        for (int k = 0; k < 5; k++) step(0, '0, '0, 1, 4'd1, 0, 1);

        // Barrier with pending stores (R8)
        step(1, 4'd7, 8'h77, 0, '0, 0, 0);
        step(1, 4'd8, 8'h88, 0, '0, 0, 0);
        step(1, 4'd9, 8'h99, 1, 4'd7, 1, 0);
        step(1, 4'd9, 8'h99, 1, 4'd7, 0, 0);
        step(1, 4'd9, 8'h99, 1, 4'd7, 0, 1);
        step(1, 4'd9, 8'h99, 1, 4'd8, 0, 1);
        step(1, 4'd9, 8'h99, 1, 4'd9, 0, 0);
        // Barrier on empty queue blocks nothing (R8)
        step(0, '0, '0, 0, '0, 0, 1);
        step(1, 4'd2, 8'hAB, 1, 4'd2, 1, 0);
        step(0, '0, '0, 1, 4'd2, 0, 1);

        // Pseudo-random mix over a narrow address range
        r = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
            r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
            step(r[0], {1'b0, r[3:1]}, r[11:4], r[12], {1'b0, r[15:13]},
                 (r[6:1] == 6'd0), r[7] | r[9]);
        end
        for (int k = 0; k < 8; k++) step(0, '0, '0, 1, 4'd3, 0, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule